// File: doc/BRIEF.md
# JTAG Configuration Status Readback Sequencer

This block is a JTAG master. It drives TCK, TMS and TDI toward one target TAP controller and samples TDO, and it reads the target's 32-bit configuration status register by running a fixed script. The script resets the TAP and loads an instruction that opens the configuration input port. It then shifts in five command words: a sync word, a no-op, a header that requests one status word, and two flush words. Next it loads an instruction that opens the configuration output port, shifts out the status word, and resets the TAP again.

A single-cycle `start` launches the script. `busy` stays high for the whole run. When the final reset cycles are complete, `done` pulses for one system clock. The captured word appears on `status` in that same cycle and holds until a later run completes. The result carries no back-pressure: `done` acts as a one-shot valid, and because `status` holds, no ready is needed. TCK runs at a fixed fraction of the system clock. The two 10-bit instruction codes are parameters.

Top module: `cfg_status_jtag_reader`

## Requirements
- R1: After reset: `busy`=0, `done`=0, `tck`=0, `tms`=1, `tdi`=0 and `status`=0.
- R2: While busy, TCK has a period of CLK_DIV system clocks (CLK_DIV even, at least 2) with equal high and low halves. TCK is low while idle.
- R3: TMS and TDI change only in the system-clock cycle in which TCK falls.
- R4: The TAP walk seen at TCK rising edges is as follows. Five TMS=1, one TMS=0, then TMS=1,1 and 0,0 before the first instruction. After each instruction, TMS=1,1 then 0,0. After the packet phase, TMS=1,1,1 then 0,0. After the status shift, five TMS=1. One run is 240 TCK cycles.
- R5: Each instruction is 10 bits and goes out LSB first on TDI. Bits 0..8 are sent with TMS=0 and bit 9 with TMS=1. The input instruction is CFG_IN_CODE and the output instruction is CFG_OUT_CODE.
- R6: The packet phase sends 160 bits with each word MSB first. The word order is 0xAA995566, 0x20000000, 0x2800E001, 0x20000000, 0x20000000. Every bit is sent with TMS=0 except the last one, which is sent with TMS=1.
- R7: TDI is 0 in every TAP-walk cycle and in every status-shift cycle. The status shift is 32 cycles, with TMS=0 on all but the last cycle, which has TMS=1.
- R8: TDO is sampled at the TCK rising edges of the 32 status-shift cycles. The first bit received lands in `status` bit 0 and the last in bit 31.
- R9: `done` is high for exactly one system clock, in the cycle after the final TCK fall, with `busy` low in that cycle.
- R10: A `start` that arrives while busy is ignored. The run still has exactly 240 TCK cycles and one `done`.
- R11: `status` keeps its value during a run and changes only when `done` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one readback script when idle |
| busy | output | 1 | High while the script runs |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Last captured status word |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select, changes on TCK fall |
| tdi | output | 1 | JTAG data toward the target |
| tdo | input | 1 | JTAG data from the target |

## Verification
Several rules are checked on every cycle by properties:
- TMS and TDI move only where TCK falls.
- TCK rests low while idle.
- The script position holds between TCK falls.
- The status register moves only on completion.
- `done` is a single-cycle pulse with `busy` already low.

The bench compares the full 240-bit TMS/TDI stream against an independently built script. It drives a different status word over TDO on each run and checks bit order. It also shows that an extra `start` during a run changes neither the cycle count nor the number of completions.

// File: rtl/jrb_pkg.sv
package jrb_pkg;
  localparam int WORD_W  = 32;
  localparam int IR_W    = 10;
  localparam int NUM_SEG = 15;

  typedef enum logic [2:0] {
    K_TMS1, K_TMS0, K_IR_IN, K_IR_OUT, K_PKT, K_CAP
  } seg_kind_e;

  typedef struct packed {
    seg_kind_e  kind;
    logic [7:0] len;
  } seg_t;

  function automatic seg_t mk(seg_kind_e k, logic [7:0] n);
    seg_t s;
    s.kind = k;
    s.len  = n;
    return s;
  endfunction

  // script: TAP walk and shift phases, in execution order
  function automatic seg_t seg_at(logic [3:0] s);
    case (s)
      4'd0:    return mk(K_TMS1, 8'd5);
      4'd1:    return mk(K_TMS0, 8'd1);
      4'd2:    return mk(K_TMS1, 8'd2);
      4'd3:    return mk(K_TMS0, 8'd2);
      4'd4:    return mk(K_IR_IN, 8'd10);
      4'd5:    return mk(K_TMS1, 8'd2);
      4'd6:    return mk(K_TMS0, 8'd2);
      4'd7:    return mk(K_PKT, 8'd160);
      4'd8:    return mk(K_TMS1, 8'd3);
      4'd9:    return mk(K_TMS0, 8'd2);
      4'd10:   return mk(K_IR_OUT, 8'd10);
      4'd11:   return mk(K_TMS1, 8'd2);
      4'd12:   return mk(K_TMS0, 8'd2);
      4'd13:   return mk(K_CAP, 8'd32);
      default: return mk(K_TMS1, 8'd5);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pkt_word(logic [2:0] w);
    case (w)
      3'd0:    return 32'hAA99_5566;
      3'd2:    return 32'h2800_E001;
      default: return 32'h2000_0000;
    endcase
  endfunction
endpackage

// File: rtl/jrb_tck_div.sv
module jrb_tck_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tck,
  output logic rise,
  output logic fall
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CW'(HALF - 1));
  assign rise = wrap && !tck;
  assign fall = wrap && tck;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  p_tck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tck);
endmodule

// File: rtl/jrb_script.sv
module jrb_script
  import jrb_pkg::*;
#(
  parameter logic [IR_W-1:0] CFG_IN_CODE  = 10'h3C5,
  parameter logic [IR_W-1:0] CFG_OUT_CODE = 10'h3C4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic tms_bit,
  output logic tdi_bit,
  output logic cap_phase,
  output logic script_end
);
  localparam logic [3:0] LAST_SEG = 4'(NUM_SEG - 1);

  logic [3:0]        seg;
  logic [7:0]        idx;
  seg_t              info;
  logic              seg_end;
  logic [WORD_W-1:0] word;

  always_comb begin
    info       = seg_at(seg);
    seg_end    = (idx == info.len - 8'd1);
    word       = pkt_word(idx[7:5]);
    tms_bit    = 1'b1;
    tdi_bit    = 1'b0;
    cap_phase  = 1'b0;
    case (info.kind)
      K_TMS0:   tms_bit = 1'b0;
      K_IR_IN: begin
        tms_bit = seg_end;
        tdi_bit = |(CFG_IN_CODE & (IR_W'(1) << idx));
      end
      K_IR_OUT: begin
        tms_bit = seg_end;
        tdi_bit = |(CFG_OUT_CODE & (IR_W'(1) << idx));
      end
      K_PKT: begin
        tms_bit = seg_end;
        tdi_bit = word[~idx[4:0]];
      end
      K_CAP: begin
        tms_bit   = seg_end;
        cap_phase = 1'b1;
      end
      default: tms_bit = 1'b1;
    endcase
    script_end = (seg == LAST_SEG) && seg_end;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      seg <= '0;
      idx <= '0;
    end else if (step) begin
      if (seg_end) begin
        idx <= '0;
        seg <= (seg == LAST_SEG) ? 4'd0 : seg + 4'd1;
      end else begin
        idx <= idx + 8'd1;
      end
    end
  end

  p_pos_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> ($stable(seg) && $stable(idx)));
endmodule

// File: rtl/jrb_capture.sv
module jrb_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         bit_in,
  input  logic         commit,
  output logic [W-1:0] status
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      status <= '0;
    end else begin
      if (sample) shreg <= {bit_in, shreg[W-1:1]};
      if (commit) status <= shreg;
    end
  end

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(status));
endmodule

// File: rtl/cfg_status_jtag_reader.sv
module cfg_status_jtag_reader
  import jrb_pkg::*;
#(
  parameter int              CLK_DIV      = 4,
  parameter logic [IR_W-1:0] CFG_IN_CODE  = 10'h3C5,
  parameter logic [IR_W-1:0] CFG_OUT_CODE = 10'h3C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] status,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  logic accept, rise, fall, finish;
  logic tms_bit, tdi_bit, cap_phase, script_end;

  assign accept = start && !busy;
  assign finish = busy && fall && script_end;

  jrb_tck_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .tck(tck), .rise(rise), .fall(fall)
  );

  jrb_script #(.CFG_IN_CODE(CFG_IN_CODE), .CFG_OUT_CODE(CFG_OUT_CODE)) u_script (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(busy && fall),
    .tms_bit(tms_bit), .tdi_bit(tdi_bit), .cap_phase(cap_phase),
    .script_end(script_end)
  );

  jrb_capture #(.W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sample(busy && rise && cap_phase),
    .bit_in(tdo), .commit(finish), .status(status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (accept)      busy <= 1'b1;
      else if (finish) busy <= 1'b0;
    end
  end

  // idle keeps the TAP parked in reset with a quiet data line
  assign tms = busy ? tms_bit : 1'b1;
  assign tdi = busy ? tdi_bit : 1'b0;

  p_pins_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tms) || !$stable(tdi)) |-> ($past(tck) && !tck));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/cfg_status_jtag_reader_test.sv
`timescale 1ns/1ps
module cfg_status_jtag_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam logic [9:0] C_IN  = 10'h3C5;
  localparam logic [9:0] C_OUT = 10'h3C4;
  localparam int CAP_FIRST  = 203;
  localparam int RUN_TCKS   = 240;

  logic clk = 0, rst_n = 0, start = 0, tdo = 0;
  logic busy, done, tck, tms, tdi;
  logic [31:0] status;

  int checks = 0, fails = 0;
  int nr = 0, base = 0, since = 0, hi_len = 0, done_cnt = 0;
  logic [31:0] stat_val = 0;
  logic [1:0] expq[$];
  logic p_tck = 0, p_tms = 1, p_tdi = 0, p_done = 0;

  cfg_status_jtag_reader #(.CLK_DIV(CLK_DIV), .CFG_IN_CODE(C_IN), .CFG_OUT_CODE(C_OUT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .status(status), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int n);
    if ((n >= 10 && n < 20) || (n >= 189 && n < 199)) return "R5";
    if (n >= 24 && n < 184) return "R6";
    if (n >= CAP_FIRST && n < CAP_FIRST + 32) return "R7";
    return "R4";
  endfunction

  // driver side of the scoreboard: expected {tms,tdi} per TCK rise
  task automatic push_n(input logic m, input logic d, input int n);
    for (int i = 0; i < n; i++) expq.push_back({m, d});
  endtask

  task automatic push_ir(input logic [9:0] code);
    for (int i = 0; i < 10; i++) expq.push_back({logic'(i == 9), code[i]});
  endtask

  task automatic build_expected();
    logic [31:0] words [5];
    words = '{32'hAA995566, 32'h20000000, 32'h2800E001, 32'h20000000, 32'h20000000};
    push_n(1, 0, 5); push_n(0, 0, 1); push_n(1, 0, 2); push_n(0, 0, 2);
    push_ir(C_IN);
    push_n(1, 0, 2); push_n(0, 0, 2);
    for (int w = 0; w < 5; w++)
      for (int b = 31; b >= 0; b--)
        expq.push_back({logic'(w == 4 && b == 0), words[w][b]});
    push_n(1, 0, 3); push_n(0, 0, 2);
    push_ir(C_OUT);
    push_n(1, 0, 2); push_n(0, 0, 2);
    for (int i = 0; i < 32; i++) expq.push_back({logic'(i == 31), 1'b0});
    push_n(1, 0, 5);
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      since++;
      hi_len++;
      if ((tms !== p_tms) || (tdi !== p_tdi))
        check(p_tck && !tck, "R3", {30'd0, tck, p_tck}, 32'd1);
      if (tck && !p_tck) begin
        if (expq.size() == 0) check(0, "R4", {30'd0, tms, tdi}, 32'hFFFF);
        else begin
          logic [1:0] e;
          e = expq.pop_front();
          check({tms, tdi} === e, tag_of(nr - base), {30'd0, tms, tdi}, {30'd0, e});
        end
        if (nr - base > 0) check(since == CLK_DIV, "R2", since, CLK_DIV);
        nr++;
        since = 0;
        hi_len = 0;
      end
      if (!tck && p_tck) begin
        check(hi_len == CLK_DIV/2, "R2", hi_len, CLK_DIV/2);
        tdo = (nr - base >= CAP_FIRST && nr - base < CAP_FIRST + 32) ?
              stat_val[nr - base - CAP_FIRST] : 1'b0;
      end
      if (done) begin
        done_cnt++;
        check(status === stat_val, "R8", status, stat_val);
        check(!busy, "R9", {31'd0, busy}, 0);
        check(nr - base == RUN_TCKS, "R10", nr - base, RUN_TCKS);
      end
      if (done && p_done) check(0, "R9", 1, 0);
      if (!busy) check(!tck, "R2", {31'd0, tck}, 0);
      p_tck = tck; p_tms = tms; p_tdi = tdi; p_done = done;
    end
  end

  task automatic run(input logic [31:0] v, input bit poke);
    logic [31:0] prev;
    int d0;
    prev = status;
    d0 = done_cnt;
    stat_val = v;
    base = nr;
    build_expected();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (100) @(negedge clk);
    check(status === prev, "R11", status, prev);
    if (poke) begin
      start = 1;
      @(negedge clk) start = 0;
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3 * CLK_DIV) @(negedge clk);
    check(done_cnt == d0 + 1, "R10", done_cnt - d0, 1);
    check(nr - base == RUN_TCKS, "R10", nr - base, RUN_TCKS);
    check(expq.size() == 0, "R4", expq.size(), 0);
    check(status === v, "R11", status, v);
    expq.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0, "R1", {31'd0, busy}, 0);
    check(done === 0, "R1", {31'd0, done}, 0);
    check(tck === 0, "R1", {31'd0, tck}, 0);
    check(tms === 1, "R1", {31'd0, tms}, 1);
    check(tdi === 0, "R1", {31'd0, tdi}, 0);
    check(status === 0, "R1", status, 0);
    run(32'hA5C3_0F1E, 0);
    run(32'h0000_0001, 1);
    run(32'h8000_0000, 0);
    run(32'hFFFF_FFFF, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule